// File: doc/BRIEF.md
# Test Access Port with Instruction-Selected Data Registers

This block is a serial test access port for a chip's debug and in-system programming paths. An external host drives a test clock, a mode-select line and a serial data input. A sixteen-state controller follows the mode-select line on each rising test-clock edge. A three-bit instruction register picks which data register sits between the serial input and the serial output.

Three data registers exist. The first is a single bypass cell. The second is a 10-bit debug register. The third is a 3-bit programming register. The debug and programming registers each pair a serial shift stage with a parallel buffer. An update commits the shifted-in word to the parallel output. On the same falling edge, it samples the parallel input, which the shift stage then presents on the next scan. The engines that consume and produce those parallel words sit outside this block.

Three instruction codes are accepted as no-ops. Each of them leaves the existing data-register selection untouched.

Top module: `jtag_tap_port`

## Requirements
- R1: While `trst_n` is low, and after it is released, the controller is in Test-Logic-Reset, the bypass cell is the selected data path, both parallel outputs read zero and `tdo_oe` is low.
- R2: With `tms` held high, the controller stays in Test-Logic-Reset. From any state, five rising `tck` edges with `tms` high bring it there.
- R3: Capture-IR loads binary 01 into the two lowest instruction shift bits, with the upper bit 0. The instruction shifts least significant bit first, so a 3-bit IR scan returns 1, 0, 0 on `tdo`.
- R4: Codes 011, 101 and 111 select the bypass cell. It captures 0 in Capture-DR and delays `tdi` by exactly one shift, so an n-bit DR scan returns 0 followed by the first n-1 input bits.
- R5: Code 010 selects the 10-bit debug register. On the falling `tck` edge in Update-DR, `dbg_par_out` takes the 10 bits shifted in, with the first bit shifted in at bit 0.
- R6: On that same Update-DR falling edge, the shift stage of the selected register is reloaded from its parallel input. The next DR scan shifts this value out least significant bit first.
- R7: Code 100 selects the 3-bit programming register, with the same update and reload behaviour on `prg_par_out` and `prg_par_in`.
- R8: Codes 000, 001 and the reserved 110 are accepted but keep whichever data register was selected before them.
- R9: Entering Test-Logic-Reset forces the bypass instruction, so the bypass cell becomes the selected path regardless of the previous instruction.
- R10: While `tck` is held low, changes on `tms` and `tdi` alter no state and no output.
- R11: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR.
- R12: A parallel buffer changes only on an Update-DR of its own register. Data-register scans never change the instruction or the data-register selection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for the `tdo` pad driver |
| dbg_par_in | input | DBG_W | Word reloaded into the debug shift stage at update |
| dbg_par_out | output | DBG_W | Debug parallel buffer |
| prg_par_in | input | PRG_W | Word reloaded into the programming shift stage at update |
| prg_par_out | output | PRG_W | Programming parallel buffer |

## Verification
The bench builds the block with its default parameters: a 3-bit instruction, a 10-bit debug register and a 3-bit programming register. At these widths every instruction code can be scanned in. Each of the three data-path lengths is observable at `tdo` and can be told apart from the others. The no-op codes can therefore be seen to keep either the debug or the programming length. The short programming register also lets the bench run repeated update-then-reload round trips within a few dozen clock cycles.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      DSEL_BYP = 2'd0,
      DSEL_DBG = 2'd1,
      DSEL_PRG = 2'd2
   } dsel_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         ST_TLR:    n = m ? ST_TLR    : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_TLR;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int               IR_W      = 3,
   parameter logic [IR_W-1:0]  CODE_DBG  = 'b010,
   parameter logic [IR_W-1:0]  CODE_PRG  = 'b100,
   parameter logic [IR_W-1:0]  CODE_NOP0 = 'b000,
   parameter logic [IR_W-1:0]  CODE_NOP1 = 'b001,
   parameter logic [IR_W-1:0]  CODE_RSVD = 'b110
)(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tdi,
   input  tap_state_e state,
   output logic       ir_so,
   output dsel_e      dsel
);

   localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);
   localparam logic [IR_W-1:0] CODE_BYP    = '1;

   logic [IR_W-1:0] ir_shift;
   logic [IR_W-1:0] ir_q;
   dsel_e           held_q;

   generate
      if (IR_W < 2) begin : g_bad_ir_w
         $error("tap_ir: IR_W must be at least 2");
      end
   endgenerate

   function automatic logic is_keep(input logic [IR_W-1:0] c);
      return (c == CODE_NOP0) || (c == CODE_NOP1) || (c == CODE_RSVD);
   endfunction

   // shift stage: capture and shift on rising tck
   generate
      if (IR_W == 2) begin : g_sh2
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                ir_shift <= CAPTURE_PAT;
            else if (state == ST_CAP_IR) ir_shift <= CAPTURE_PAT;
            else if (state == ST_SH_IR)  ir_shift <= {tdi, ir_shift[1]};
         end
      end else begin : g_shn
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                ir_shift <= CAPTURE_PAT;
            else if (state == ST_CAP_IR) ir_shift <= CAPTURE_PAT;
            else if (state == ST_SH_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
         end
      end
   endgenerate

   // instruction latch on falling tck
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_q   <= CODE_BYP;
         held_q <= DSEL_BYP;
      end else if (state == ST_TLR) begin
         ir_q   <= CODE_BYP;
         held_q <= DSEL_BYP;
      end else if (state == ST_UPD_IR) begin
         ir_q   <= ir_shift;
         held_q <= dsel;
      end
   end

   always_comb begin
      if (is_keep(ir_q))         dsel = held_q;
      else if (ir_q == CODE_DBG) dsel = DSEL_DBG;
      else if (ir_q == CODE_PRG) dsel = DSEL_PRG;
      else                       dsel = DSEL_BYP;
   end

   assign ir_so = ir_shift[0];

endmodule

// File: rtl/tap_dreg.sv
module tap_dreg
   import tap_pkg::*;
#(
   parameter int W = 10
)(
   input  logic         tck,
   input  logic         trst_n,
   input  logic         sel,
   input  logic         tdi,
   input  tap_state_e   state,
   input  logic [W-1:0] par_in,
   output logic [W-1:0] par_out,
   output logic         so
);

   logic [W-1:0] sr;
   logic [W-1:0] snap;

   generate
      if (W < 1) begin : g_bad_w
         $error("tap_dreg: W must be at least 1");
      end
   endgenerate

   // rising edge: shift, or take the word sampled at the last update
   generate
      if (W == 1) begin : g_one
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                          sr <= '0;
            else if (sel && state == ST_SH_DR)    sr <= tdi;
            else if (sel && state == ST_UPD_DR)   sr <= snap;
         end
      end else begin : g_wide
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n)                          sr <= '0;
            else if (sel && state == ST_SH_DR)    sr <= {tdi, sr[W-1:1]};
            else if (sel && state == ST_UPD_DR)   sr <= snap;
         end
      end
   endgenerate

   // falling edge in update: commit shifted word, sample parallel input
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         par_out <= '0;
         snap    <= '0;
      end else if (sel && state == ST_UPD_DR) begin
         par_out <= sr;
         snap    <= par_in;
      end
   end

   assign so = sr[0];

endmodule

// File: rtl/jtag_tap_port.sv
module jtag_tap_port
   import tap_pkg::*;
#(
   parameter int               IR_W      = 3,
   parameter int               DBG_W     = 10,
   parameter int               PRG_W     = 3,
   parameter logic [IR_W-1:0]  CODE_DBG  = 'b010,
   parameter logic [IR_W-1:0]  CODE_PRG  = 'b100,
   parameter logic [IR_W-1:0]  CODE_NOP0 = 'b000,
   parameter logic [IR_W-1:0]  CODE_NOP1 = 'b001,
   parameter logic [IR_W-1:0]  CODE_RSVD = 'b110
)(
   input  logic             tck,
   input  logic             trst_n,
   input  logic             tms,
   input  logic             tdi,
   output logic             tdo,
   output logic             tdo_oe,
   input  logic [DBG_W-1:0] dbg_par_in,
   output logic [DBG_W-1:0] dbg_par_out,
   input  logic [PRG_W-1:0] prg_par_in,
   output logic [PRG_W-1:0] prg_par_out
);

   localparam logic [IR_W-1:0] CODE_BYP = '1;

   generate
      if (CODE_DBG == CODE_PRG || CODE_DBG == CODE_BYP || CODE_PRG == CODE_BYP) begin : g_bad_codes
         $error("jtag_tap_port: function codes must be distinct from each other and from all-ones");
      end
      if (DBG_W < 1 || PRG_W < 1) begin : g_bad_widths
         $error("jtag_tap_port: data register widths must be at least 1");
      end
   endgenerate

   tap_state_e state_q;
   dsel_e      dsel;
   logic       ir_so;
   logic       dbg_so;
   logic       prg_so;
   logic       byp_q;
   logic       dr_so;
   logic       tdo_q;
   logic       oe_q;

   tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (state_q)
   );

   tap_ir #(
      .IR_W      (IR_W),
      .CODE_DBG  (CODE_DBG),
      .CODE_PRG  (CODE_PRG),
      .CODE_NOP0 (CODE_NOP0),
      .CODE_NOP1 (CODE_NOP1),
      .CODE_RSVD (CODE_RSVD)
   ) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .tdi    (tdi),
      .state  (state_q),
      .ir_so  (ir_so),
      .dsel   (dsel)
   );

   tap_dreg #(.W(DBG_W)) u_dbg (
      .tck     (tck),
      .trst_n  (trst_n),
      .sel     (dsel == DSEL_DBG),
      .tdi     (tdi),
      .state   (state_q),
      .par_in  (dbg_par_in),
      .par_out (dbg_par_out),
      .so      (dbg_so)
   );

   tap_dreg #(.W(PRG_W)) u_prg (
      .tck     (tck),
      .trst_n  (trst_n),
      .sel     (dsel == DSEL_PRG),
      .tdi     (tdi),
      .state   (state_q),
      .par_in  (prg_par_in),
      .par_out (prg_par_out),
      .so      (prg_so)
   );

   // single bypass cell
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                byp_q <= 1'b0;
      else if (dsel == DSEL_BYP) begin
         if (state_q == ST_CAP_DR)     byp_q <= 1'b0;
         else if (state_q == ST_SH_DR) byp_q <= tdi;
      end
   end

   always_comb begin
      case (dsel)
         DSEL_DBG: dr_so = dbg_so;
         DSEL_PRG: dr_so = prg_so;
         default:  dr_so = byp_q;
      endcase
   end

   // output stage retimed to falling tck
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         oe_q  <= (state_q == ST_SH_IR) || (state_q == ST_SH_DR);
         tdo_q <= (state_q == ST_SH_IR) ? ir_so : dr_so;
      end
   end

   assign tdo    = tdo_q;
   assign tdo_oe = oe_q;

endmodule

// File: rtl/tap_checker.sv
module tap_checker
   import tap_pkg::*;
#(
   parameter int               IR_W      = 3,
   parameter int               DBG_W     = 10,
   parameter int               PRG_W     = 3,
   parameter logic [IR_W-1:0]  CODE_NOP0 = 'b000,
   parameter logic [IR_W-1:0]  CODE_NOP1 = 'b001,
   parameter logic [IR_W-1:0]  CODE_RSVD = 'b110
)(
   input logic             tck,
   input logic             trst_n,
   input logic             tms,
   input tap_state_e       state,
   input dsel_e            dsel,
   input logic [IR_W-1:0]  ir_shift,
   input logic [IR_W-1:0]  ir_q,
   input logic             tdo_oe,
   input logic [DBG_W-1:0] dbg_par_out,
   input logic [PRG_W-1:0] prg_par_out
);

   logic keep_code;
   assign keep_code = (ir_shift == CODE_NOP0) || (ir_shift == CODE_NOP1) || (ir_shift == CODE_RSVD);

   p_tlr_hold_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR && tms) |=> (state == ST_TLR));

   p_keep_sel_r8: assert property (@(negedge tck) disable iff (!trst_n)
      (state == ST_UPD_IR && keep_code) |=> $stable(dsel));

   p_tlr_bypass_r9: assert property (@(negedge tck) disable iff (!trst_n)
      (state == ST_TLR) |=> (dsel == DSEL_BYP && ir_q == '1));

   p_oe_window_r11: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (state == ST_SH_IR || state == ST_SH_DR));

   p_ir_kept_r12: assert property (@(negedge tck) disable iff (!trst_n)
      (state != ST_UPD_IR && state != ST_TLR) |=> ($stable(ir_q) && $stable(dsel)));

   p_dbg_buf_r12: assert property (@(negedge tck) disable iff (!trst_n)
      !(state == ST_UPD_DR && dsel == DSEL_DBG) |=> $stable(dbg_par_out));

   p_prg_buf_r12: assert property (@(negedge tck) disable iff (!trst_n)
      !(state == ST_UPD_DR && dsel == DSEL_PRG) |=> $stable(prg_par_out));

endmodule

bind jtag_tap_port tap_checker #(
   .IR_W      (IR_W),
   .DBG_W     (DBG_W),
   .PRG_W     (PRG_W),
   .CODE_NOP0 (CODE_NOP0),
   .CODE_NOP1 (CODE_NOP1),
   .CODE_RSVD (CODE_RSVD)
) u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .tms         (tms),
   .state       (state_q),
   .dsel        (dsel),
   .ir_shift    (u_ir.ir_shift),
   .ir_q        (u_ir.ir_q),
   .tdo_oe      (tdo_oe),
   .dbg_par_out (dbg_par_out),
   .prg_par_out (prg_par_out)
);

// File: tb/jtag_tap_port_bench.sv
module jtag_tap_port_bench;

   localparam int TCK_PERIOD = 20;
   localparam int HALF       = TCK_PERIOD / 2;
   localparam int DBG_W      = 10;
   localparam int PRG_W      = 3;

   logic             tck = 1'b0;
   logic             trst_n = 1'b0;
   logic             tms = 1'b1;
   logic             tdi = 1'b0;
   logic             tdo;
   logic             tdo_oe;
   logic [DBG_W-1:0] dbg_par_in = '0;
   logic [DBG_W-1:0] dbg_par_out;
   logic [PRG_W-1:0] prg_par_in = '0;
   logic [PRG_W-1:0] prg_par_out;

   jtag_tap_port u_jtag_tap_port (
      .tck         (tck),
      .trst_n      (trst_n),
      .tms         (tms),
      .tdi         (tdi),
      .tdo         (tdo),
      .tdo_oe      (tdo_oe),
      .dbg_par_in  (dbg_par_in),
      .dbg_par_out (dbg_par_out),
      .prg_par_in  (prg_par_in),
      .prg_par_out (prg_par_out)
   );

   typedef struct {
      logic  v;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   bit   done = 0;

   // expected contents of the shift stages
   logic [DBG_W-1:0] dbg_shadow = '0;
   logic [PRG_W-1:0] prg_shadow = '0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // one test-clock period; inputs change while tck is low
   task automatic step(input logic m, input logic d);
      tms = m;
      tdi = d;
      #(HALF) tck = 1'b1;
      #(HALF) tck = 1'b0;
      #1;
   endtask

   task automatic load_ir(input logic [2:0] code);
      step(1, 0); step(1, 0); step(0, 0); step(0, 0);
      exp_q.push_back('{1'b1, "R3"});
      exp_q.push_back('{1'b0, "R3"});
      exp_q.push_back('{1'b0, "R3"});
      for (int i = 0; i < 3; i++) step(i == 2, code[i]);
      step(1, 0);
      step(0, 0);
   endtask

   task automatic scan_dr(input int n, input logic [31:0] data,
                          input logic [31:0] expout, input string tag);
      step(1, 0); step(0, 0);
      check("R11 oe in capture", {31'b0, tdo_oe}, 32'd0);
      step(0, 0);
      for (int i = 0; i < n; i++) exp_q.push_back('{expout[i], tag});
      for (int i = 0; i < n; i++) step(i == n - 1, data[i]);
      step(1, 0);
      step(0, 0);
      check("R11 oe in idle", {31'b0, tdo_oe}, 32'd0);
   endtask

   function automatic logic [31:0] byp_out(input logic [31:0] d);
      return {d[30:0], 1'b0};
   endfunction

   // monitor: compare each shifted-out bit against the scoreboard
   always @(posedge tck) begin
      if (trst_n && tdo_oe) begin
         if (exp_q.size() == 0) begin
            n_checks++;
            n_errors++;
            $display("FAIL R11: tdo active with no expected bit, actual=%0b expected=none", tdo);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check({e.tag, " tdo bit"}, {31'b0, tdo}, {31'b0, e.v});
         end
      end
   end

   initial begin
      #(TCK_PERIOD * 200000);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      #(HALF * 3);
      check("R1 oe", {31'b0, tdo_oe}, 32'd0);
      check("R1 dbg buf", {22'b0, dbg_par_out}, 32'd0);
      check("R1 prg buf", {29'b0, prg_par_out}, 32'd0);
      trst_n = 1'b1;
      #(HALF);

      // R2: hold in reset state with tms high
      for (int i = 0; i < 6; i++) step(1, 0);
      check("R2 oe in reset state", {31'b0, tdo_oe}, 32'd0);
      step(0, 0);
      scan_dr(6, 32'h2D, byp_out(32'h2D), "R1");

      // R3/R4: bypass codes
      load_ir(3'b111);
      scan_dr(8, 32'hB2, byp_out(32'hB2), "R4");
      load_ir(3'b011);
      scan_dr(8, 32'h4D, byp_out(32'h4D), "R4");
      load_ir(3'b101);
      scan_dr(5, 32'h13, byp_out(32'h13), "R4");

      // R5: debug register update
      load_ir(3'b010);
      dbg_par_in = 10'h2A5;
      scan_dr(DBG_W, 32'h1C3, {22'b0, dbg_shadow}, "R5");
      check("R5 dbg buf", {22'b0, dbg_par_out}, 32'h1C3);
      check("R12 prg buf untouched", {29'b0, prg_par_out}, 32'd0);
      dbg_shadow = 10'h2A5;

      // R6: reload from parallel input
      dbg_par_in = 10'h3F0;
      scan_dr(DBG_W, 32'h055, {22'b0, dbg_shadow}, "R6");
      check("R6 dbg buf", {22'b0, dbg_par_out}, 32'h055);
      dbg_shadow = 10'h3F0;

      // R7: programming register
      load_ir(3'b100);
      prg_par_in = 3'b110;
      scan_dr(PRG_W, 32'h5, {29'b0, prg_shadow}, "R7");
      check("R7 prg buf", {29'b0, prg_par_out}, 32'h5);
      prg_shadow = 3'b110;
      prg_par_in = 3'b001;
      scan_dr(PRG_W, 32'h3, {29'b0, prg_shadow}, "R7");
      check("R7 prg buf second", {29'b0, prg_par_out}, 32'h3);
      prg_shadow = 3'b001;
      check("R12 dbg buf untouched", {22'b0, dbg_par_out}, 32'h055);

      // R8: keep codes retain the programming selection
      load_ir(3'b000);
      prg_par_in = 3'b100;
      scan_dr(PRG_W, 32'h2, {29'b0, prg_shadow}, "R8");
      check("R8 prg buf after 000", {29'b0, prg_par_out}, 32'h2);
      prg_shadow = 3'b100;
      load_ir(3'b001);
      scan_dr(PRG_W, 32'h7, {29'b0, prg_shadow}, "R8");
      prg_shadow = 3'b100;
      load_ir(3'b110);
      scan_dr(PRG_W, 32'h1, {29'b0, prg_shadow}, "R8");
      check("R8 prg buf after 110", {29'b0, prg_par_out}, 32'h1);
      // keep codes retain the debug selection
      load_ir(3'b010);
      load_ir(3'b001);
      scan_dr(DBG_W, 32'h0F0, {22'b0, dbg_shadow}, "R8");
      check("R8 dbg buf after 001", {22'b0, dbg_par_out}, 32'h0F0);

      // R9: reset state forces bypass
      for (int i = 0; i < 5; i++) step(1, 0);
      step(0, 0);
      scan_dr(4, 32'hB, byp_out(32'hB), "R9");
      check("R12 dbg buf after bypass scan", {22'b0, dbg_par_out}, 32'h0F0);

      // R10: no clock, inputs wiggle
      for (int i = 0; i < 20; i++) begin
         tms = i[0];
         tdi = i[1];
         #(HALF);
      end
      check("R10 oe", {31'b0, tdo_oe}, 32'd0);
      check("R10 dbg buf", {22'b0, dbg_par_out}, 32'h0F0);
      check("R10 prg buf", {29'b0, prg_par_out}, 32'h1);
      scan_dr(6, 32'h29, byp_out(32'h29), "R10");

      check("R11 all expected bits seen", exp_q.size(), 32'd0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule